// File: doc/BRIEF.md
# GPIO Pad Bank with Register Control

This block controls a bank of 95 general-purpose pads through a small 32-bit register bus. The bus carries a byte address, a write strobe, write data and combinational read data. Each pad has two 32-bit configuration words. The first word selects native function or GPIO, sets direction, holds the driven level and reports the sampled input level. The second word turns input sensing on or off and selects the weak pull.

The bank drives these per-pad outputs: output enable, output value, pull-up, pull-down, and a flag that shows whether the pad is in GPIO mode. Native-function routing is represented only by that flag.

An ownership bitmap marks pads that platform firmware has reserved. A 0 bit means the pad is reserved. The bitmap is packed 32 pads per word and can only be written while the bus marks the access as privileged. The bus has no handshake: every write completes on the clock edge that samples it, and reads are combinational from the address.

Top module: `gpio_pad_bank`

## Requirements
- R1: After reset, every configuration word 1 reads 0x00000004 and every configuration word 2 reads 0x00000004. Reset leaves each pad an input in native mode, with sensing disabled and no pull. Every ownership word reads 0, and all pad output enables, pulls and GPIO flags are 0.
- R2: Configuration word 1 of pad p is at byte address 0x100 + 8*p and word 2 is at 0x104 + 8*p. A write changes only the addressed word of the addressed pad.
- R3: In word 1, bit 31 is the output level and drives pad_out[p]. Bit 2 is direction (1 = input, 0 = output) and bits 1:0 are use-select, stored as written. All other bits read 0.
- R4: pad_oe[p] is 1 only when use-select equals 1 (GPIO) and direction is 0 (output).
- R5: In word 2, bit 2 disables input sensing when 1. Bits 1:0 select the pull: 1 asserts pad_pull_dn[p], 2 asserts pad_pull_up[p], and 0 or 3 asserts neither. Other bits read 0.
- R6: Word 1 bit 30 is read-only. It follows pad_in[p] through two flops while sensing is enabled, and reads 0 from the cycle after sensing is disabled. Writing bit 30 has no effect.
- R7: The ownership bitmap is at 0x00, 0x04 and 0x08. Pad p is bit p mod 32 of the word at (p/32)*4. A write changes it only when bus_fw_priv is 1. The bit for the nonexistent pad 95 (word 0x08, bit 31) reads 0.
- R8: Reads of unmapped or misaligned addresses return 0, and writes to them change nothing. This includes 0x0C, 0xFC, 0x101, and 0x3F8 (pad 95 and above).
- R9: pad_gpio_sel[p] is 1 exactly when use-select equals 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_wr_en | input | 1 | Write strobe |
| bus_fw_priv | input | 1 | Privileged (firmware) access qualifier |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 95 | Pad input levels |
| pad_out | output | 95 | Pad output values |
| pad_oe | output | 95 | Pad output enables |
| pad_pull_up | output | 95 | Weak pull-up enables |
| pad_pull_dn | output | 95 | Weak pull-down enables |
| pad_gpio_sel | output | 95 | 1 = pad in GPIO mode, 0 = native function |

## Verification
Two functions can act on the same bit in one cycle: a bus write to word 1 carrying bit 30 set, and the synchronizer updating that bit from a pad that has just gone low. The bench drives both in the same cycle and reads the word back a few cycles later. The result must show the pad level and ignore the written value. The bench also disables sensing while the pad is held high and checks that the level bit reads 0 on the next read.

// File: rtl/gpb_pkg.sv
package gpb_pkg;
  typedef enum logic [1:0] {
    USE_NATIVE = 2'd0,
    USE_GPIO   = 2'd1,
    USE_ALT2   = 2'd2,
    USE_ALT3   = 2'd3
  } use_sel_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2,
    PULL_RSVD = 2'd3
  } pull_e;

  localparam int BIT_OUT_LVL = 31;
  localparam int BIT_IN_LVL  = 30;
  localparam int BIT_DIR_IN  = 2;
  localparam int BIT_SNS_DIS = 2;
endpackage

// File: rtl/gpb_in_sync.sv
module gpb_in_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic d,
  output logic q
);
  logic s1_q, s2_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= d;
      s2_q <= s1_q;
    end
  end

  assign q = s2_q;

  AST_SENSE_OFF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q); // R6
endmodule

// File: rtl/gpb_own_map.sv
module gpb_own_map #(
  parameter int NPINS  = 95,
  parameter int NWORDS = (NPINS + 31) / 32,
  parameter int OIW    = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic           fw_priv,
  input  logic [OIW-1:0] idx,
  input  logic [31:0]    wdata,
  output logic [31:0]    rd_word
);
  logic [NWORDS-1:0][31:0] own_q;
  logic [NWORDS-1:0][31:0] live_mask;

  for (genvar w = 0; w < NWORDS; w++) begin : g_mask
    for (genvar b = 0; b < 32; b++) begin : g_bit
      assign live_mask[w][b] = ((w * 32 + b) < NPINS);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own_q <= '0;
    end else if (wr && fw_priv) begin
      own_q[idx] <= wdata & live_mask[idx];
    end
  end

  assign rd_word = own_q[idx];

  AST_OWN_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && fw_priv) |=> $stable(own_q)); // R7
endmodule

// File: rtl/gpb_pin_cfg.sv
module gpb_pin_cfg
  import gpb_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr1,
  input  logic        wr2,
  input  logic [31:0] wdata,
  input  logic        pad_in,
  output logic [31:0] rd1,
  output logic [31:0] rd2,
  output logic        pad_oe,
  output logic        pad_out,
  output logic        pad_pu,
  output logic        pad_pd,
  output logic        pad_gpio
);
  logic     out_q, dir_in_q, sns_dis_q, in_lvl;
  use_sel_e use_q;
  pull_e    pull_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q    <= 1'b0;
      dir_in_q <= 1'b1;
      use_q    <= USE_NATIVE;
    end else if (wr1) begin
      out_q    <= wdata[BIT_OUT_LVL];
      dir_in_q <= wdata[BIT_DIR_IN];
      use_q    <= use_sel_e'(wdata[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sns_dis_q <= 1'b1;
      pull_q    <= PULL_NONE;
    end else if (wr2) begin
      sns_dis_q <= wdata[BIT_SNS_DIS];
      pull_q    <= pull_e'(wdata[1:0]);
    end
  end

  gpb_in_sync u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (sns_dis_q),
    .d     (pad_in),
    .q     (in_lvl)
  );

  assign rd1      = {out_q, in_lvl, 27'd0, dir_in_q, use_q};
  assign rd2      = {29'd0, sns_dis_q, pull_q};
  assign pad_gpio = (use_q == USE_GPIO);
  assign pad_oe   = pad_gpio && !dir_in_q;
  assign pad_out  = out_q;
  assign pad_pu   = (pull_q == PULL_UP);
  assign pad_pd   = (pull_q == PULL_DOWN);

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr1 |=> $stable({out_q, dir_in_q, use_q})); // R2
  AST_OUT_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr1 |=> (pad_out == $past(wdata[BIT_OUT_LVL]))); // R3
  AST_OE_GPIO_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    pad_oe |-> pad_gpio); // R4
  AST_PULL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pad_pu, pad_pd})); // R5
endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank #(
  parameter int NPINS    = 95,
  parameter int AW       = 12,
  parameter int OWN_BASE = 'h000,
  parameter int CFG_BASE = 'h100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic             bus_wr_en,
  input  logic             bus_fw_priv,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic [NPINS-1:0] pad_in,
  output logic [NPINS-1:0] pad_out,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] pad_pull_up,
  output logic [NPINS-1:0] pad_pull_dn,
  output logic [NPINS-1:0] pad_gpio_sel
);
  localparam int NWORDS = (NPINS + 31) / 32;
  localparam int OIW    = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam int PIW    = $clog2(NPINS);
  localparam logic [AW-1:0] OWN_B    = AW'(OWN_BASE);
  localparam logic [AW-1:0] CFG_B    = AW'(CFG_BASE);
  localparam logic [AW-1:0] OWN_SPAN = AW'(4 * NWORDS);
  localparam logic [AW-4:0] NPINS_W  = (AW-3)'(NPINS);

  logic [AW-1:0]  own_rel, cfg_rel;
  logic           own_hit, cfg_hit, word2_sel;
  logic [AW-4:0]  pin_full;
  logic [PIW-1:0] pin_idx;
  logic [31:0]    own_rd;
  logic [31:0]    rd1 [NPINS];
  logic [31:0]    rd2 [NPINS];

  assign own_rel   = bus_addr - OWN_B;
  assign cfg_rel   = bus_addr - CFG_B;
  assign own_hit   = (own_rel < OWN_SPAN) && (bus_addr[1:0] == 2'b00);
  assign pin_full  = cfg_rel[AW-1:3];
  assign cfg_hit   = (pin_full < NPINS_W) && (cfg_rel[1:0] == 2'b00);
  assign pin_idx   = pin_full[PIW-1:0];
  assign word2_sel = cfg_rel[2];

  gpb_own_map #(.NPINS(NPINS), .NWORDS(NWORDS), .OIW(OIW)) u_own (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (bus_wr_en && own_hit),
    .fw_priv (bus_fw_priv),
    .idx     (own_rel[OIW+1:2]),
    .wdata   (bus_wdata),
    .rd_word (own_rd)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic sel;
    assign sel = bus_wr_en && cfg_hit && (pin_idx == PIW'(p));
    gpb_pin_cfg u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr1      (sel && !word2_sel),
      .wr2      (sel && word2_sel),
      .wdata    (bus_wdata),
      .pad_in   (pad_in[p]),
      .rd1      (rd1[p]),
      .rd2      (rd2[p]),
      .pad_oe   (pad_oe[p]),
      .pad_out  (pad_out[p]),
      .pad_pu   (pad_pull_up[p]),
      .pad_pd   (pad_pull_dn[p]),
      .pad_gpio (pad_gpio_sel[p])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (own_hit)        bus_rdata = own_rd;
    else if (cfg_hit)   bus_rdata = word2_sel ? rd2[pin_idx] : rd1[pin_idx];
  end

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(own_hit || cfg_hit) |-> (bus_rdata == 32'd0)); // R8
  AST_OE_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) && !$past(bus_wr_en) |-> $stable(pad_oe)); // R4
endmodule

// File: tb/test_gpio_pad_bank.sv
`timescale 1ns/1ps
module test_gpio_pad_bank;
  localparam int NP = 95;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [11:0]   bus_addr = '0;
  logic          bus_wr_en = 1'b0;
  logic          bus_fw_priv = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe, pad_pull_up, pad_pull_dn, pad_gpio_sel;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_pad_bank i_gpio_pad_bank (
    .clk, .rst_n, .bus_addr, .bus_wr_en, .bus_fw_priv, .bus_wdata, .bus_rdata,
    .pad_in, .pad_out, .pad_oe, .pad_pull_up, .pad_pull_dn, .pad_gpio_sel
  );

  typedef struct packed {
    logic        wr;
    logic        fw;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] expv;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 12'h100, 32'h0000_0000, 32'h0000_0004, 4'd1}, // R1 word 1 reset
    '{1'b0, 1'b0, 12'h3F4, 32'h0000_0000, 32'h0000_0004, 4'd1}, // R1 word 2 pad 94
    '{1'b0, 1'b0, 12'h000, 32'h0000_0000, 32'h0000_0000, 4'd1}, // R1 ownership
    '{1'b1, 1'b0, 12'h100, 32'hFFFF_FFFF, 32'h8000_0007, 4'd3}, // R3 field mask
    '{1'b1, 1'b0, 12'h100, 32'h4000_0001, 32'h0000_0001, 4'd6}, // R6 bit 30 ignored
    '{1'b0, 1'b0, 12'h108, 32'h0000_0000, 32'h0000_0004, 4'd2}, // R2 pad 1 untouched
    '{1'b1, 1'b0, 12'h3F0, 32'h8000_0001, 32'h8000_0001, 4'd2}, // R2 pad 94 word 1
    '{1'b1, 1'b0, 12'h104, 32'hFFFF_FFFE, 32'h0000_0006, 4'd5}, // R5 word 2 mask
    '{1'b1, 1'b0, 12'h104, 32'h0000_0001, 32'h0000_0001, 4'd5}, // R5 pull-down, sense on
    '{1'b1, 1'b0, 12'h000, 32'hFFFF_FFFF, 32'h0000_0000, 4'd7}, // R7 unprivileged
    '{1'b1, 1'b1, 12'h000, 32'hA5A5_A5A5, 32'hA5A5_A5A5, 4'd7}, // R7 privileged
    '{1'b1, 1'b1, 12'h008, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 4'd7}, // R7 pad 95 bit absent
    '{1'b1, 1'b1, 12'h00C, 32'hFFFF_FFFF, 32'h0000_0000, 4'd8}, // R8 past bitmap
    '{1'b1, 1'b0, 12'h3F8, 32'hFFFF_FFFF, 32'h0000_0000, 4'd8}, // R8 pad 95
    '{1'b1, 1'b0, 12'h101, 32'h8000_0000, 32'h0000_0000, 4'd8}, // R8 misaligned
    '{1'b1, 1'b0, 12'h0FC, 32'h0000_0001, 32'h0000_0000, 4'd8}, // R8 gap
    '{1'b0, 1'b0, 12'h100, 32'h0000_0000, 32'h0000_0001, 4'd8}  // R8 pad 0 kept
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL R%0d: actual %08h expected %08h", req, act, expv);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d, input logic fw);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_fw_priv = fw; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_fw_priv = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr_en = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R9: outputs after reset
    check(1, {1'b0, pad_oe[30:0]} | 32'(|pad_oe), 32'd0);
    check(1, 32'(|{pad_pull_up, pad_pull_dn}), 32'd0);
    check(9, 32'(|pad_gpio_sel), 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) bus_write(VECS[i].addr, VECS[i].wdata, VECS[i].fw);
      bus_read(VECS[i].addr, r);
      check(int'(VECS[i].req), r, VECS[i].expv);
    end

    // R4 / R9 / R5 pad outputs after table
    check(4, {30'd0, pad_oe[94], pad_oe[0]}, 32'd3);
    check(4, 32'(pad_oe[1]), 32'd0);
    check(3, 32'(pad_out[94]), 32'd1);
    check(9, {30'd0, pad_gpio_sel[1], pad_gpio_sel[0]}, 32'd1);
    check(5, {30'd0, pad_pull_up[0], pad_pull_dn[0]}, 32'd1);

    // R4: native alternate mode with output direction gives no enable
    bus_write(12'h100, 32'h0000_0002, 1'b0);
    check(4, {30'd0, pad_gpio_sel[0], pad_oe[0]}, 32'd0);
    // R4: GPIO input gives no enable
    bus_write(12'h100, 32'h0000_0005, 1'b0);
    check(4, {30'd0, pad_gpio_sel[0], pad_oe[0]}, 32'd2);
    bus_write(12'h100, 32'h0000_0001, 1'b0);

    // R5: reserved pull code and pull-up
    bus_write(12'h104, 32'h0000_0003, 1'b0);
    check(5, {30'd0, pad_pull_up[0], pad_pull_dn[0]}, 32'd0);
    bus_write(12'h104, 32'h0000_0002, 1'b0);
    check(5, {30'd0, pad_pull_up[0], pad_pull_dn[0]}, 32'd2);

    // R6: sensing enabled, level follows pad
    pad_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(12'h100, r);
    check(6, r, 32'h4000_0001);
    // R6: pad falls in the cycle of a write carrying bit 30 set
    @(negedge clk);
    pad_in[0] = 1'b0;
    bus_addr = 12'h100; bus_wdata = 32'h4000_0001; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    repeat (3) @(negedge clk);
    bus_read(12'h100, r);
    check(6, r, 32'h0000_0001);
    // R6: disable sensing while pad is high
    pad_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    bus_write(12'h104, 32'h0000_0005, 1'b0);
    bus_read(12'h100, r);
    check(6, r, 32'h0000_0001);
    // R2: pad 1 level stays 0 (sensing off from reset) with its pad high
    pad_in[1] = 1'b1;
    repeat (3) @(negedge clk);
    bus_read(12'h108, r);
    check(2, r, 32'h0000_0004);

    done = 1'b1;
    finish_run();
  end
endmodule